// File: doc/BRIEF.md
# Thread Mailbox and Semaphore Cell

This block is one shared synchronisation cell that several hardware threads use to pass data or count events. At reset it takes on one of two personalities, picked by the `mode_fifo` pin: an eight-entry queue of 64-bit words, or a 16-bit counting semaphore that saturates at its maximum value. Every request carries a 3-bit view code that selects how the access acts on the cell. The raw view reaches the storage directly. The status view reads and writes the tag flags. The empty/full views push and pop the queue. The P/V views take and give the semaphore. The empty/full and P/V views each come in a blocking flavour and a polling flavour.

A blocking access that cannot complete does not change the data. The cell answers with a stall flag and marks the requesting thread in an internal waiter mask. The empty/full views clear their opposite flag before this check, and that clear still takes effect on a stall. Any empty/full access that goes ahead, and any P/V give, releases the recorded waiters. The cell drives a one-cycle wake strobe with the mask of those threads and then clears the mask. The scheduler that parks and resumes threads sits outside this block.

Requests arrive on a valid/ready port. `req_ready` is always high, so the cell never applies back-pressure. Every request with `req_valid` high is accepted in that cycle. Exactly one cycle later the cell presents one response beat with `rsp_valid`, carrying read data and the stall flag. The response cannot be held off, so the requester must take it in that cycle. The wake strobe, when present, is aligned with that response beat.

Top module: `itc_cell`

## Requirements
- R1: During reset the cell loads its personality from `mode_fifo`. A queue cell reads back the status word 0x3002_0001 (depth code 3, queue flag, empty). A semaphore cell reads back 0.
- R2: A status-view read (view 1) returns the depth code in bits 31:28 (3 for a queue, 0 for a semaphore), the fill count in bits 21:18, the queue flag in bit 17, T in bit 16, F in bit 1 and E in bit 0.
- R3: A status-view write loads T, E and F from write-data bits 16, 0 and 1. When the new E is 1 it also empties the queue (fill count 0).
- R4: An empty/full write (view 2 blocking, view 3 polling) in queue mode clears E, then appends below capacity and sets F when the count reaches 8. A polling write to a full queue is dropped.
- R5: An empty/full read (view 2 or 3) in queue mode clears F, then returns the oldest entry and removes it. E is set once the count is 0. A polling read of an empty queue returns 0 without a stall.
- R6: A blocking empty/full read while E=1, or a blocking write while F=1, returns a stall and records the thread ID in the waiter mask. It changes no data, count or pointer.
- R7: An empty/full access that proceeds, or any P/V write, raises `wake_valid` together with the waiter mask when that mask is nonzero, and leaves the mask empty.
- R8: A P/V read (view 4 blocking, view 5 polling) in semaphore mode returns the count and decrements it when nonzero. At zero the blocking read stalls and the polling read returns 0 without stalling.
- R9: A P/V write in semaphore mode increments the count, ignores the write data, and saturates at 0xFFFF.
- R10: Empty/full views act as reads of 0 with no effect in semaphore mode. P/V views act the same way in queue mode.
- R11: A raw-view (view 0) read returns the oldest queue entry or the semaphore count. A raw write replaces the newest queue entry when the queue is non-empty, and is ignored in semaphore mode.
- R12: `req_ready` is always 1. Each accepted request yields exactly one `rsp_valid` beat in the next cycle. `rsp_stall` is only high with `rsp_valid`.
- R13: View codes 6 and 7 read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_fifo | input | 1 | Personality sampled during reset: 1 queue, 0 semaphore |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; request accepted when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_view | input | 3 | Access view code |
| req_tid | input | 3 | Requesting thread ID |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response beat, one cycle after the request |
| rsp_rdata | output | 64 | Read data (0 for writes and stalls) |
| rsp_stall | output | 1 | Requesting thread must wait |
| wake_valid | output | 1 | One-cycle release strobe |
| wake_mask | output | 8 | Threads released by this strobe |

## Verification
The bench walks the queue's read and write pointers around the ring. It then fills the queue to capacity and pushes once more, so a design that overwrote the oldest entry or wrapped the count would return wrong data on the drain. Blocking accesses are made against an empty and a full queue, and against a zero semaphore. A design that moved data on a stall, lost a waiter, or failed to clear the mask after a wake would show a wrong strobe or extra entries. A status write with E set must discard queued words. Driving the semaphore far past 0xFFFF exposes any counter that wraps to zero. Accesses through the wrong personality's views must leave the count visible through the raw view unchanged.

// File: rtl/itc_pkg.sv
package itc_pkg;

  // Access views carried with every request
  typedef enum logic [2:0] {
    VW_PASS     = 3'd0,
    VW_STATUS   = 3'd1,
    VW_EF_BLOCK = 3'd2,
    VW_EF_POLL  = 3'd3,
    VW_PV_BLOCK = 3'd4,
    VW_PV_POLL  = 3'd5
  } itc_view_e;

  // Status word field positions (software decodes these)
  localparam int STS_DEPTH_LSB = 28;
  localparam int STS_FILL_LSB  = 18;
  localparam int STS_MODE_BIT  = 17;
  localparam int STS_T_BIT     = 16;
  localparam int STS_F_BIT     = 1;
  localparam int STS_E_BIT     = 0;
  localparam int STS_DEPTH_W   = 4;

endpackage

// File: rtl/itc_fifo_store.sv
module itc_fifo_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [DEPTH-1:0][WIDTH-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (wr_idx == PTR_W'(i))) mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/itc_wait_tracker.sv
module itc_wait_tracker #(
  parameter int THREADS = 8,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               block_en,
  input  logic [TID_W-1:0]   block_tid,
  input  logic               wake_en,
  output logic               wake_valid,
  output logic [THREADS-1:0] wake_mask
);

  logic [THREADS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      wake_valid <= wake_en && (mask_q != '0);
      wake_mask  <= wake_en ? mask_q : '0;
      if (wake_en) mask_q <= '0;
      if (block_en) mask_q[block_tid] <= 1'b1;
    end
  end

  // R7: a strobe always names at least one thread
  p_wake_names_thread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (wake_mask != '0));

  // R7: releasing waiters empties the mask
  p_wake_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && !block_en) |=> (mask_q == '0));

  // R6: a stalled thread is remembered
  p_block_records_r6: assert property (@(posedge clk) disable iff (!rst_n)
    block_en |=> mask_q[$past(block_tid)]);

endmodule

// File: rtl/itc_cell.sv
module itc_cell
  import itc_pkg::*;
#(
  parameter int DEPTH_LOG2 = 3,
  parameter int WIDTH      = 64,
  parameter int THREADS    = 8,
  parameter int SEM_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_fifo,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [2:0]                 req_view,
  input  logic [$clog2(THREADS)-1:0] req_tid,
  input  logic [WIDTH-1:0]           req_wdata,
  output logic                       rsp_valid,
  output logic [WIDTH-1:0]           rsp_rdata,
  output logic                       rsp_stall,
  output logic                       wake_valid,
  output logic [THREADS-1:0]         wake_mask
);

  localparam int DEPTH     = 1 << DEPTH_LOG2;
  localparam int PTR_W     = DEPTH_LOG2;
  localparam int CNT_W     = DEPTH_LOG2 + 1;
  localparam int TID_W     = $clog2(THREADS);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);

  // Cell state
  logic             is_fifo_q;
  logic             tag_t_q, tag_e_q, tag_f_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] out_q;
  logic [SEM_W-1:0] sem_q;

  logic             tag_t_d, tag_e_d, tag_f_d;
  logic [CNT_W-1:0] cnt_d;
  logic [PTR_W-1:0] out_d;
  logic [SEM_W-1:0] sem_d;

  // Storage and waiter side
  logic             st_we;
  logic [PTR_W-1:0] st_widx;
  logic [WIDTH-1:0] st_rdata;
  logic             block_en;
  logic             wake_en;

  logic [WIDTH-1:0] rdata_d;
  logic             stall_d;
  logic [WIDTH-1:0] status_word;
  logic [PTR_W-1:0] push_idx, newest_idx;
  logic             blocking;
  itc_view_e        view;

  assign req_ready  = 1'b1;
  assign view       = itc_view_e'(req_view);
  assign push_idx   = out_q + cnt_q[PTR_W-1:0];
  assign newest_idx = out_q + cnt_q[PTR_W-1:0] - PTR_W'(1);
  assign blocking   = (view == VW_EF_BLOCK) || (view == VW_PV_BLOCK);

  always_comb begin
    status_word = '0;
    status_word[STS_DEPTH_LSB +: STS_DEPTH_W] = is_fifo_q ? STS_DEPTH_W'(DEPTH_LOG2) : '0;
    status_word[STS_FILL_LSB +: CNT_W] = cnt_q;
    status_word[STS_MODE_BIT] = is_fifo_q;
    status_word[STS_T_BIT]    = tag_t_q;
    status_word[STS_F_BIT]    = tag_f_q;
    status_word[STS_E_BIT]    = tag_e_q;
  end

  itc_fifo_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_we),
    .wr_idx  (st_widx),
    .wr_data (req_wdata),
    .rd_idx  (out_q),
    .rd_data (st_rdata)
  );

  itc_wait_tracker #(
    .THREADS (THREADS)
  ) u_waiters (
    .clk        (clk),
    .rst_n      (rst_n),
    .block_en   (block_en),
    .block_tid  (req_tid),
    .wake_en    (wake_en),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask)
  );

  // Access decode: one request per cycle, result applied at the next edge
  always_comb begin
    tag_t_d  = tag_t_q;
    tag_e_d  = tag_e_q;
    tag_f_d  = tag_f_q;
    cnt_d    = cnt_q;
    out_d    = out_q;
    sem_d    = sem_q;
    st_we    = 1'b0;
    st_widx  = push_idx;
    rdata_d  = '0;
    stall_d  = 1'b0;
    block_en = 1'b0;
    wake_en  = 1'b0;

    if (req_valid) begin
      case (view)
        VW_PASS: begin
          if (req_write) begin
            if (is_fifo_q && (cnt_q != '0)) begin
              st_we   = 1'b1;
              st_widx = newest_idx;
            end
          end else begin
            rdata_d = is_fifo_q ? st_rdata : WIDTH'(sem_q);
          end
        end

        VW_STATUS: begin
          if (req_write) begin
            tag_t_d = req_wdata[STS_T_BIT];
            tag_e_d = req_wdata[STS_E_BIT];
            tag_f_d = req_wdata[STS_F_BIT];
            if (req_wdata[STS_E_BIT]) cnt_d = '0;
          end else begin
            rdata_d = status_word;
          end
        end

        VW_EF_BLOCK, VW_EF_POLL: begin
          if (is_fifo_q) begin
            if (!req_write) begin
              tag_f_d = 1'b0;
              if (blocking && tag_e_q) begin
                stall_d  = 1'b1;
                block_en = 1'b1;
              end else begin
                wake_en = 1'b1;
                if (cnt_q != '0) begin
                  rdata_d = st_rdata;
                  out_d   = out_q + PTR_W'(1);
                  cnt_d   = cnt_q - CNT_W'(1);
                end
                if (cnt_q <= CNT_W'(1)) tag_e_d = 1'b1;
              end
            end else begin
              tag_e_d = 1'b0;
              if (blocking && tag_f_q) begin
                stall_d  = 1'b1;
                block_en = 1'b1;
              end else begin
                wake_en = 1'b1;
                if (cnt_q < FULL_CNT) begin
                  st_we = 1'b1;
                  cnt_d = cnt_q + CNT_W'(1);
                end
                if (cnt_q >= LAST_CNT) tag_f_d = 1'b1;
              end
            end
          end
        end

        VW_PV_BLOCK, VW_PV_POLL: begin
          if (!is_fifo_q) begin
            if (req_write) begin
              if (sem_q != '1) sem_d = sem_q + SEM_W'(1);
              wake_en = 1'b1;
            end else begin
              rdata_d = WIDTH'(sem_q);
              if (sem_q != '0) begin
                sem_d = sem_q - SEM_W'(1);
              end else if (blocking) begin
                stall_d  = 1'b1;
                block_en = 1'b1;
              end
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_fifo_q <= mode_fifo;
      tag_t_q   <= 1'b0;
      tag_e_q   <= mode_fifo;
      tag_f_q   <= 1'b0;
      cnt_q     <= '0;
      out_q     <= '0;
      sem_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_stall <= 1'b0;
    end else begin
      tag_t_q   <= tag_t_d;
      tag_e_q   <= tag_e_d;
      tag_f_q   <= tag_f_d;
      cnt_q     <= cnt_d;
      out_q     <= out_d;
      sem_q     <= sem_d;
      rsp_valid <= req_valid;
      rsp_rdata <= rdata_d;
      rsp_stall <= stall_d;
    end
  end

  // R12: one response beat per accepted request, in the next cycle
  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_stall_with_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> rsp_valid);

  // R4: the fill count never passes capacity, and reaching it sets F
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  p_full_on_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_q == FULL_CNT) |-> tag_f_q);

  // R5: draining to zero leaves E set
  p_empty_on_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && ($past(cnt_q) != '0)) |-> tag_e_q);

  // R9: the semaphore holds at its ceiling
  p_sem_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sem_q == '1) && req_valid && req_write && !is_fifo_q &&
     ((view == VW_PV_BLOCK) || (view == VW_PV_POLL))) |=> (sem_q == '1));

  // R6: a stalled access never releases waiters
  p_stall_no_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> !wake_valid);

endmodule

// File: tb/itc_cell_tb.sv
`timescale 1ns/1ps
module itc_cell_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_fifo = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_view = '0;
  logic [2:0]  req_tid = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_stall;
  logic        wake_valid;
  logic [7:0]  wake_mask;

  always #4 clk = ~clk;  // 125 MHz

  itc_cell u_dut (
    .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [63:0] got_data;
  logic        got_stall, got_valid, got_wv;
  logic [7:0]  got_wm;

  // Vector: {req#(4), write(1), view(3), tid(3), wdata(32), expected(32), stall(1)}
  localparam int NV = 44;
  localparam logic [75:0] VEC [NV] = '{
    {4'd1,  1'b0, 3'd1, 3'd0, 32'h0,  32'h3002_0001, 1'b0}, // R1 reset status
    {4'd5,  1'b0, 3'd3, 3'd0, 32'h0,  32'h0,         1'b0}, // R5 poll empty
    {4'd4,  1'b1, 3'd2, 3'd0, 32'hA0, 32'h0,         1'b0}, // R4
    {4'd4,  1'b1, 3'd2, 3'd1, 32'hA1, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd2, 32'hA2, 32'h0,         1'b0},
    {4'd2,  1'b0, 3'd1, 3'd0, 32'h0,  32'h300E_0000, 1'b0}, // R2 fill 3
    {4'd11, 1'b0, 3'd0, 3'd0, 32'h0,  32'hA0,        1'b0}, // R11 oldest
    {4'd11, 1'b1, 3'd0, 3'd0, 32'hB2, 32'h0,         1'b0}, // R11 newest
    {4'd5,  1'b0, 3'd3, 3'd0, 32'h0,  32'hA0,        1'b0}, // R5 order
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hA1,        1'b0},
    {4'd11, 1'b0, 3'd2, 3'd0, 32'h0,  32'hB2,        1'b0}, // R11 replaced
    {4'd5,  1'b0, 3'd1, 3'd0, 32'h0,  32'h3002_0001, 1'b0}, // R5 E set
    {4'd10, 1'b0, 3'd4, 3'd0, 32'h0,  32'h0,         1'b0}, // R10
    {4'd10, 1'b1, 3'd5, 3'd0, 32'h9,  32'h0,         1'b0},
    {4'd10, 1'b0, 3'd1, 3'd0, 32'h0,  32'h3002_0001, 1'b0},
    {4'd13, 1'b1, 3'd6, 3'd0, 32'h7,  32'h0,         1'b0}, // R13
    {4'd13, 1'b0, 3'd7, 3'd0, 32'h0,  32'h0,         1'b0},
    {4'd13, 1'b0, 3'd1, 3'd0, 32'h0,  32'h3002_0001, 1'b0},
    {4'd3,  1'b1, 3'd1, 3'd0, 32'h1_0000, 32'h0,     1'b0}, // R3 T=1 E=0
    {4'd3,  1'b0, 3'd1, 3'd0, 32'h0,  32'h3003_0000, 1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hC0, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hC1, 32'h0,         1'b0},
    {4'd3,  1'b1, 3'd1, 3'd0, 32'h1,  32'h0,         1'b0}, // R3 E=1 flush
    {4'd3,  1'b0, 3'd1, 3'd0, 32'h0,  32'h3002_0001, 1'b0},
    {4'd3,  1'b0, 3'd3, 3'd0, 32'h0,  32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD0, 32'h0,         1'b0}, // R4 fill
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD1, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD2, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD3, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD4, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD5, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD6, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hD7, 32'h0,         1'b0},
    {4'd4,  1'b1, 3'd3, 3'd0, 32'hEE, 32'h0,         1'b0}, // R4 dropped
    {4'd4,  1'b0, 3'd1, 3'd0, 32'h0,  32'h3022_0002, 1'b0}, // R4 full
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD0,        1'b0}, // R5 drain
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD1,        1'b0},
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD2,        1'b0},
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD3,        1'b0},
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD4,        1'b0},
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD5,        1'b0},
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD6,        1'b0},
    {4'd5,  1'b0, 3'd2, 3'd0, 32'h0,  32'hD7,        1'b0},
    {4'd5,  1'b0, 3'd1, 3'd0, 32'h0,  32'h3002_0001, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge; sample the response one cycle later
  task automatic access(input logic w, input logic [2:0] v, input logic [2:0] tid,
                        input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_view = v; req_tid = tid; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    got_valid = rsp_valid; got_data = rsp_rdata; got_stall = rsp_stall;
    got_wv = wake_valid; got_wm = wake_mask;
  endtask

  task automatic do_reset(input logic fifo);
    @(negedge clk);
    rst_n = 1'b0; mode_fifo = fifo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    check("R12 ready", 64'(req_ready), 64'd1);
    check("R12 idle", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      string tag;
      v = VEC[i];
      access(v[71], v[70:68], v[67:65], 64'(v[64:33]));
      tag = $sformatf("R%0d vec%0d", v[75:72], i);
      check(tag, got_data, 64'(v[32:1]));
      check(tag, 64'(got_stall), 64'(v[0]));
      check("R12 beat", 64'(got_valid), 64'd1);
    end

    // R6 / R7: blocking reads on an empty queue, then a push releases them
    access(1'b0, 3'd2, 3'd2, 64'h0);
    check("R6 stall read", 64'(got_stall), 64'd1);
    check("R6 no wake", 64'(got_wv), 64'd0);
    access(1'b0, 3'd2, 3'd5, 64'h0);
    check("R6 stall read2", 64'(got_stall), 64'd1);
    access(1'b1, 3'd3, 3'd0, 64'h77);
    check("R7 wake", 64'(got_wv), 64'd1);
    check("R7 mask", 64'(got_wm), 64'h24);
    access(1'b0, 3'd3, 3'd0, 64'h0);
    check("R7 data kept", got_data, 64'h77);
    check("R7 mask cleared", 64'(got_wv), 64'd0);

    // R6: blocking write on a full queue
    for (int i = 0; i < 8; i++) access(1'b1, 3'd3, 3'd0, 64'hE0 + 64'(i));
    access(1'b1, 3'd2, 3'd1, 64'hFF);
    check("R6 stall write", 64'(got_stall), 64'd1);
    access(1'b0, 3'd1, 3'd0, 64'h0);
    check("R6 full unchanged", got_data, 64'h3022_0002);
    access(1'b0, 3'd3, 3'd0, 64'h0);
    check("R6 head", got_data, 64'hE0);
    check("R7 wake writer", 64'(got_wm), 64'h02);
    for (int i = 1; i < 8; i++) begin
      access(1'b0, 3'd3, 3'd0, 64'h0);
      check("R5 tail", got_data, 64'hE0 + 64'(i));
    end

    // Semaphore personality
    do_reset(1'b0);
    access(1'b0, 3'd1, 3'd0, 64'h0);
    check("R1 sem reset", got_data, 64'h0);
    access(1'b0, 3'd5, 3'd0, 64'h0);
    check("R8 poll zero", got_data, 64'h0);
    check("R8 poll no stall", 64'(got_stall), 64'd0);
    access(1'b0, 3'd4, 3'd3, 64'h0);
    check("R8 block stall", 64'(got_stall), 64'd1);
    access(1'b1, 3'd4, 3'd0, 64'hDEAD);
    check("R7 pv wake", 64'(got_wm), 64'h08);
    check("R9 write rdata", got_data, 64'h0);
    access(1'b0, 3'd5, 3'd0, 64'h0);
    check("R8 take", got_data, 64'h1);
    access(1'b0, 3'd5, 3'd0, 64'h0);
    check("R8 after take", got_data, 64'h0);
    for (int i = 0; i < 3; i++) access(1'b1, 3'd5, 3'd0, 64'h0);
    access(1'b0, 3'd0, 3'd0, 64'h0);
    check("R11 sem raw", got_data, 64'h3);
    access(1'b1, 3'd0, 3'd0, 64'h99);
    access(1'b0, 3'd0, 3'd0, 64'h0);
    check("R11 raw write ignored", got_data, 64'h3);
    access(1'b1, 3'd3, 3'd0, 64'h5);
    access(1'b1, 3'd2, 3'd0, 64'h5);
    check("R10 ef write sem", 64'(got_stall), 64'd0);
    access(1'b0, 3'd2, 3'd0, 64'h0);
    check("R10 ef read sem", got_data, 64'h0);
    check("R10 ef no stall", 64'(got_stall), 64'd0);
    access(1'b0, 3'd0, 3'd0, 64'h0);
    check("R10 count kept", got_data, 64'h3);

    // R9: saturate with a back-to-back burst
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_view = 3'd5; req_wdata = 64'h0;
    repeat (65535) @(negedge clk);
    req_valid = 1'b0;
    access(1'b0, 3'd0, 3'd0, 64'h0);
    check("R9 saturate", got_data, 64'hFFFF);
    access(1'b1, 3'd4, 3'd0, 64'h0);
    access(1'b0, 3'd0, 3'd0, 64'h0);
    check("R9 hold", got_data, 64'hFFFF);
    access(1'b0, 3'd5, 3'd0, 64'h0);
    check("R8 take max", got_data, 64'hFFFF);
    access(1'b0, 3'd0, 3'd0, 64'h0);
    check("R8 decremented", got_data, 64'hFFFE);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule